// File: doc/BRIEF.md
# Chaos-Controlled Bit-Matrix Scrambler

This block scrambles a byte stream. It gathers eight input bytes into an 8x8 bit matrix, with the first byte as row 0. It then rotates every row and after that every column. The direction and distance of each rotation come from control bits. A 16-bit fixed-point logistic map produces these bits, and its starting value is loaded from a key seed. The same block restores the original bytes when it is loaded with the same seed in decrypt mode. In that mode it regenerates the identical control bits, undoes the column rotations first, undoes the row rotations after them, and turns every rotation the other way.

Both data sides are valid/ready byte streams. The block takes in one set of eight bytes. It transforms that set in two cycles, one for all rows and one for all columns. It then hands out the eight result bytes, starting with row 0. No new byte is accepted until the set has fully left the block. The chaotic generator advances only when a byte is accepted, so backpressure on the output stalls both the input and the generator.

Top module: `bitmat_scrambler`

## Requirements
- R1: After reset, `in_ready` is high and `out_valid` is low. The generator state after reset is 0x5A3C and the mode is encrypt.
- R2: `in_ready` is high only while a set is being collected. Exactly eight bytes are accepted per set, and `in_ready` stays low from the eighth acceptance until the last byte of that set has been handed out.
- R3: A seed load sets the generator state to `seed_val`. A seed of 0x0000 or 0xC000 (the map's stuck points) is replaced by 0x5A3C. Each step computes x' = min(floor(x*(65536-x)/16384), 65535), and if the result is 0x0000 or 0xC000 it becomes 0x5A3C instead. The state is never 0x0000 or 0xC000, and it changes only on a seed load or a byte acceptance.
- R4: When byte i of a set (i = 0..7) is accepted, the control byte is the upper eight state bits, taken before the step. Bits 7:4 steer row i and bits 3:0 steer column i. Within each nibble the top bit selects the function (0 = rotate left, 1 = rotate right) and the lower three bits give the distance k.
- R5: In encrypt mode, all rows are rotated in one cycle and then all columns in the next. A left rotation by k maps out[j] = in[(j-k) mod 8]. Column c is the vector whose element r is bit c of row r.
- R6: `decrypt` is sampled at a seed load. In decrypt mode the columns are rotated first and the rows second, both in the direction opposite to the selector, so that decrypting a ciphertext with the same seed returns the plaintext.
- R7: `out_valid` rises on the third clock edge after the eighth byte is accepted. Bytes leave in row order 0..7, and `out_valid` and `out_data` hold steady while `out_ready` is low.
- R8: A seed load discards any partly collected or undrained set and restarts collection at row 0. `in_ready` is low during the load cycle and high in the cycle after it, unless the load is held.
- R9: Ciphertexts of the same plaintext under seeds that differ in one bit are not identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the key seed and mode, and restart set collection |
| seed_val | input | 16 | Key seed for the chaotic generator |
| decrypt | input | 1 | Mode sampled at seed load: 1 = decrypt, 0 = encrypt |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte, row order |

## Verification
The bench encrypts random streams under random output backpressure and random input gaps, then decrypts the result with the same seed. A design that applies the passes in the same order in both modes, or keeps the same rotation direction, fails to recover the plaintext. A degenerate seed must produce the same ciphertext as the default seed, and a one-bit seed change must alter the ciphertext. A generator that steps on stalled cycles, or keeps a stuck value, drifts away from the cycle-accurate model. A seed load in the middle of a set checks that stale rows never leak out. Holding `out_ready` low checks that no byte is dropped or repeated.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,
        PH_PASS1 = 2'd1,
        PH_PASS2 = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;

    // Number of bits needed to encode a rotation distance for an n-bit vector.
    function automatic int amt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bms_rot.sv
module bms_rot #(
    parameter int N  = 8,
    parameter int KW = bms_pkg::amt_bits(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic          left_i,
    input  logic [KW-1:0] amt_i,
    output logic [N-1:0]  vec_o
);

    // Rotation as an index remap: left by k takes element (j-k) mod N.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            if (left_i) begin
                vec_o[j] = vec_i[(j + N - int'(amt_i)) % N];
            end else begin
                vec_o[j] = vec_i[(j + int'(amt_i)) % N];
            end
        end
    end

endmodule

// File: rtl/bms_plane_pass.sv
module bms_plane_pass #(
    parameter int N    = 8,
    parameter bit COLS = 1'b0,
    parameter int KW   = bms_pkg::amt_bits(N),
    parameter int CW   = KW + 1
) (
    input  logic [N*N-1:0]  mat_i,
    input  logic [N*CW-1:0] ctl_i,
    input  logic            invert_i,
    output logic [N*N-1:0]  mat_o
);

    for (genvar ln = 0; ln < N; ln++) begin : g_lane
        logic [N-1:0] lane_vec;
        logic [N-1:0] lane_rot;
        logic         lane_left;

        // Selector 0 means left in the forward direction; invert flips it.
        assign lane_left = ~(ctl_i[ln*CW + CW - 1] ^ invert_i);

        if (COLS) begin : g_col
            for (genvar r = 0; r < N; r++) begin : g_bit
                assign lane_vec[r]        = mat_i[r*N + ln];
                assign mat_o[r*N + ln]    = lane_rot[r];
            end
        end else begin : g_row
            assign lane_vec           = mat_i[ln*N +: N];
            assign mat_o[ln*N +: N]   = lane_rot;
        end

        bms_rot #(.N(N), .KW(KW)) u_rot (
            .vec_i  (lane_vec),
            .left_i (lane_left),
            .amt_i  (ctl_i[ln*CW +: KW]),
            .vec_o  (lane_rot)
        );
    end

endmodule

// File: rtl/bms_chaos_gen.sv
module bms_chaos_gen #(
    parameter int          XW           = 16,
    parameter int          OW           = 8,
    parameter int unsigned DEFAULT_SEED = 32'h5A3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [XW-1:0] seed_i,
    input  logic          step_i,
    output logic [OW-1:0] ctl_o,
    output logic [XW-1:0] state_o
);

    localparam int            PW     = 2*XW + 1;
    localparam logic [XW-1:0] DFLT   = XW'(DEFAULT_SEED);
    localparam logic [XW-1:0] STUCK  = XW'(3) << (XW - 2);
    localparam logic [XW-1:0] MAXV   = {XW{1'b1}};
    localparam logic [XW:0]   ONE    = {1'b1, {XW{1'b0}}};

    typedef struct packed {
        logic [XW-1:0] x;
    } gen_t;

    gen_t gen_d, gen_q;

    function automatic logic [XW-1:0] scrub(input logic [XW-1:0] v);
        return ((v == '0) || (v == STUCK)) ? DFLT : v;
    endfunction

    function automatic logic [XW-1:0] map_step(input logic [XW-1:0] v);
        logic [PW-1:0] prod;
        logic [PW-1:0] scaled;
        prod   = PW'(v) * PW'(ONE - {1'b0, v});
        scaled = prod >> (XW - 2);
        if (scaled > PW'(MAXV)) begin
            return scrub(MAXV);
        end
        return scrub(scaled[XW-1:0]);
    endfunction

    always_comb begin
        gen_d = gen_q;
        if (load_i) begin
            gen_d.x = scrub(seed_i);
        end else if (step_i) begin
            gen_d.x = map_step(gen_q.x);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '{x: DFLT};
        end else begin
            gen_q <= gen_d;
        end
    end

    assign ctl_o   = gen_q.x[XW-1 -: OW];
    assign state_o = gen_q.x;

endmodule

// File: rtl/bitmat_scrambler.sv
module bitmat_scrambler #(
    parameter int          N            = 8,
    parameter int          XW           = 16,
    parameter int unsigned DEFAULT_SEED = 32'h5A3C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed_load,
    input  logic [XW-1:0] seed_val,
    input  logic          decrypt,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [N-1:0]  in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [N-1:0]  out_data
);
    import bms_pkg::*;

    localparam int KW   = amt_bits(N);
    localparam int CW   = KW + 1;
    localparam int GW   = 2 * CW;
    localparam int CNTW = amt_bits(N);
    localparam logic [CNTW-1:0] LAST = CNTW'(N - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNTW-1:0]   cnt;
        logic [N*N-1:0]    mat;
        logic [N*CW-1:0]   ctl_row;
        logic [N*CW-1:0]   ctl_col;
        logic              dec;
    } core_t;

    core_t core_d, core_q;

    logic            accept;
    logic [GW-1:0]   gen_ctl;
    logic [XW-1:0]   gen_x;
    logic [N*N-1:0]  row_res;
    logic [N*N-1:0]  col_res;

    bms_chaos_gen #(
        .XW           (XW),
        .OW           (GW),
        .DEFAULT_SEED (DEFAULT_SEED)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (seed_load),
        .seed_i  (seed_val),
        .step_i  (accept),
        .ctl_o   (gen_ctl),
        .state_o (gen_x)
    );

    bms_plane_pass #(.N(N), .COLS(1'b0), .KW(KW), .CW(CW)) u_rows (
        .mat_i    (core_q.mat),
        .ctl_i    (core_q.ctl_row),
        .invert_i (core_q.dec),
        .mat_o    (row_res)
    );

    bms_plane_pass #(.N(N), .COLS(1'b1), .KW(KW), .CW(CW)) u_cols (
        .mat_i    (core_q.mat),
        .ctl_i    (core_q.ctl_col),
        .invert_i (core_q.dec),
        .mat_o    (col_res)
    );

    always_comb begin
        core_d    = core_q;
        in_ready  = (core_q.phase == PH_FILL) && !seed_load;
        accept    = in_valid && in_ready;
        out_valid = (core_q.phase == PH_DRAIN);
        out_data  = core_q.mat[int'(core_q.cnt)*N +: N];

        if (seed_load) begin
            core_d.phase = PH_FILL;
            core_d.cnt   = '0;
            core_d.dec   = decrypt;
        end else begin
            unique case (core_q.phase)
                PH_FILL: begin
                    if (accept) begin
                        core_d.mat[int'(core_q.cnt)*N +: N]      = in_data;
                        core_d.ctl_row[int'(core_q.cnt)*CW +: CW] = gen_ctl[GW-1 -: CW];
                        core_d.ctl_col[int'(core_q.cnt)*CW +: CW] = gen_ctl[CW-1:0];
                        if (core_q.cnt == LAST) begin
                            core_d.phase = PH_PASS1;
                            core_d.cnt   = '0;
                        end else begin
                            core_d.cnt = core_q.cnt + CNTW'(1);
                        end
                    end
                end
                PH_PASS1: begin
                    core_d.mat   = core_q.dec ? col_res : row_res;
                    core_d.phase = PH_PASS2;
                end
                PH_PASS2: begin
                    core_d.mat   = core_q.dec ? row_res : col_res;
                    core_d.phase = PH_DRAIN;
                    core_d.cnt   = '0;
                end
                PH_DRAIN: begin
                    if (out_ready) begin
                        if (core_q.cnt == LAST) begin
                            core_d.phase = PH_FILL;
                            core_d.cnt   = '0;
                        end else begin
                            core_d.cnt = core_q.cnt + CNTW'(1);
                        end
                    end
                end
                default: core_d.phase = PH_FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{phase: PH_FILL, cnt: '0, mat: '0,
                        ctl_row: '0, ctl_col: '0, dec: 1'b0};
        end else begin
            core_q <= core_d;
        end
    end

endmodule

// File: rtl/bms_checker.sv
module bms_checker #(
    parameter int N  = 8,
    parameter int XW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seed_load,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [N-1:0]  out_data,
    input logic [XW-1:0] gen_x
);

    localparam logic [XW-1:0] STUCK = XW'(3) << (XW - 2);

    // R2
    fill_drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !seed_load) |=> (out_valid && $stable(out_data)));

    // R8
    load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> (in_ready || seed_load));

    // R3
    gen_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !(in_valid && in_ready)) |=> $stable(gen_x));

    // R3
    gen_not_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_x != '0) && (gen_x != STUCK));

endmodule

bind bitmat_scrambler bms_checker #(.N(N), .XW(XW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seed_load (seed_load),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .gen_x     (gen_x)
);

// File: tb/bitmat_scrambler_test.sv
module bitmat_scrambler_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = '0;
    logic        decrypt = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit bp_en  = 1'b0;

    logic [7:0] got[$];
    logic [7:0] plain[$];
    logic [7:0] cipher[$];
    logic [7:0] other[$];

    // behavioural reference state
    int         m_phase = 0;
    int         m_cnt   = 0;
    int         m_x     = 23100;
    bit         m_dec   = 1'b0;
    logic [7:0] m_row[8];
    logic [7:0] m_ctl[8];

    always #5 clk = ~clk;

    bitmat_scrambler uut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .decrypt(decrypt), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int scrub(input int v);
        return (v == 0 || v == 49152) ? 23100 : v;
    endfunction

    function automatic int lmap(input int v);
        longint r;
        r = (longint'(v) * longint'(65536 - v)) / 16384;
        if (r > 65535) r = 65535;
        return scrub(int'(r));
    endfunction

    function automatic logic [7:0] rot8(input logic [7:0] v, input bit left, input int k);
        logic [7:0] o;
        for (int j = 0; j < 8; j++) o[j] = left ? v[(j - k + 8) % 8] : v[(j + k) % 8];
        return o;
    endfunction

    task automatic model_rows();
        for (int r = 0; r < 8; r++)
            m_row[r] = rot8(m_row[r], (m_ctl[r][7] == 1'b0) ^ m_dec, int'(m_ctl[r][6:4]));
    endtask

    task automatic model_cols();
        logic [7:0] cv;
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) cv[r] = m_row[r][c];
            cv = rot8(cv, (m_ctl[c][3] == 1'b0) ^ m_dec, int'(m_ctl[c][2:0]));
            for (int r = 0; r < 8; r++) m_row[r][c] = cv[r];
        end
    endtask

    // cycle-accurate comparison, then model update
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_x = 23100; m_dec = 1'b0;
        end else begin
            check(in_ready === ((m_phase == 0) && !seed_load), "R2", 32'(in_ready),
                  32'((m_phase == 0) && !seed_load), "in_ready");
            check(out_valid === (m_phase == 3), "R7", 32'(out_valid), 32'(m_phase == 3), "out_valid");
            if (m_phase == 3)
                check(out_data === m_row[m_cnt], m_dec ? "R6" : "R5", 32'(out_data),
                      32'(m_row[m_cnt]), "out_data");
            if (seed_load) begin
                m_x = scrub(int'(seed_val)); m_dec = decrypt; m_phase = 0; m_cnt = 0;
            end else begin
                case (m_phase)
                    0: if (in_valid) begin
                        m_row[m_cnt] = in_data;
                        m_ctl[m_cnt] = 8'(m_x >> 8);   // R4
                        m_x = lmap(m_x);               // R3
                        if (m_cnt == 7) begin m_phase = 1; m_cnt = 0; end
                        else m_cnt++;
                    end
                    1: begin if (m_dec) model_cols(); else model_rows(); m_phase = 2; end
                    2: begin if (m_dec) model_rows(); else model_cols(); m_phase = 3; m_cnt = 0; end
                    default: if (out_ready) begin
                        if (m_cnt == 7) begin m_phase = 0; m_cnt = 0; end
                        else m_cnt++;
                    end
                endcase
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n && out_valid && out_ready) got.push_back(out_data);
    end

    always @(negedge clk) out_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R7 watchdog: cycles %0d expected below %0d", cyc, 150000);
            report();
        end
    end

    task automatic load_seed(input logic [15:0] s, input bit dec);
        @(negedge clk);
        in_valid = 1'b0; seed_load = 1'b1; seed_val = s; decrypt = dec;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    task automatic send(input logic [7:0] q[$], input bit gaps);
        for (int i = 0; i < q.size(); i++) begin
            bit acc;
            @(negedge clk);
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_data = q[i];
            do begin
                @(posedge clk);
                acc = in_ready;
            end while (!acc);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_out(input int n);
        while (got.size() < n) @(negedge clk);
    endtask

    task automatic run(input logic [15:0] s, input bit dec, input logic [7:0] src[$]);
        load_seed(s, dec);
        got.delete();
        send(src, 1'b1);
        wait_out(src.size());
    endtask

    initial begin
        int diff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready === 1'b1, "R1", 32'(in_ready), 1, "in_ready after reset");
        check(out_valid === 1'b0, "R1", 32'(out_valid), 0, "out_valid after reset");

        // R5 and R7: encrypt three random sets with backpressure
        for (int i = 0; i < 24; i++) plain.push_back(8'($urandom));
        bp_en = 1'b1;
        run(16'h3A71, 1'b0, plain);
        cipher = got;
        check(cipher.size() == 24, "R2", 32'(cipher.size()), 24, "ciphertext length");

        // R6: decrypt with the same seed gives the plaintext
        run(16'h3A71, 1'b1, cipher);
        for (int i = 0; i < 24; i++)
            check(got[i] === plain[i], "R6", 32'(got[i]), 32'(plain[i]), "round trip");

        // R9: one seed bit flipped changes the ciphertext
        run(16'h3A70, 1'b0, plain);
        diff = 0;
        for (int i = 0; i < 24; i++) if (got[i] !== cipher[i]) diff++;
        check(diff > 0, "R9", 32'(diff), 1, "differing ciphertext bytes");

        // R3: stuck seeds behave as the default seed
        bp_en = 1'b0;
        run(16'h5A3C, 1'b0, plain);
        other = got;
        run(16'h0000, 1'b0, plain);
        for (int i = 0; i < 8; i++)
            check(got[i] === other[i], "R3", 32'(got[i]), 32'(other[i]), "zero seed");
        run(16'hC000, 1'b0, plain);
        for (int i = 0; i < 8; i++)
            check(got[i] === other[i], "R3", 32'(got[i]), 32'(other[i]), "stuck seed");

        // R4: single set bit patterns, checked against model each clock
        plain.delete();
        for (int i = 0; i < 8; i++) plain.push_back(8'h01 << i);
        run(16'h1234, 1'b0, plain);
        cipher = got;
        run(16'h1234, 1'b1, cipher);
        for (int i = 0; i < 8; i++)
            check(got[i] === plain[i], "R4", 32'(got[i]), 32'(plain[i]), "diagonal round trip");

        // R8: abort a partial set with a seed load
        load_seed(16'hBEEF, 1'b0);
        got.delete();
        plain.delete();
        for (int i = 0; i < 3; i++) plain.push_back(8'hA5);
        send(plain, 1'b0);
        plain.delete();
        for (int i = 0; i < 8; i++) plain.push_back(8'($urandom));
        run(16'hBEEF, 1'b0, plain);
        repeat (20) @(negedge clk);
        check(got.size() == 8, "R8", 32'(got.size()), 8, "bytes after aborted set");
        check(in_ready === 1'b1, "R8", 32'(in_ready), 1, "collecting again");

        report();
    end

endmodule